// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating analog-to-digital converter. It steps the analog switches through three phases in a loop. Auto-zero comes first, then a fixed-length integration of the input signal, then de-integration against the reference. During de-integration it counts clock cycles until the comparator reports that the integrator has crossed zero. The count at the crossing is captured into result registers together with the input polarity and an over-range flag. A status flag marks the time between the start of integration and the point at which a fresh result is available.

A run/hold input controls pacing. While it is held high, conversions run back to back with fixed phase lengths. Pulling it low after the zero crossing cuts de-integration short, and the sequencer then rests in auto-zero. Raising it again starts the next integration after a fixed wake-up delay. The comparator output is sampled once at the end of integration to fix the polarity. During de-integration, a change of the comparator away from that polarity counts as the zero crossing.

Top module: `dsseq_top`

## Requirements
- R1: Exactly one of the three phase outputs is high in every cycle. After reset the block is in auto-zero with status low, and count, polarity and over-range are all zero.
- R2: Auto-zero lasts at least AZ_CNT clock cycles. With run/hold high at its end, integration follows directly, so auto-zero lasts exactly AZ_CNT cycles in continuous operation.
- R3: Integration lasts exactly INT_CNT cycles. The comparator level sampled at the last integration clock becomes the polarity (1 = comparator high). It is held unchanged through de-integration and reported on the polarity output.
- R4: The zero crossing is the first de-integration clock at which the comparator differs from the held polarity. The latched count equals the number of de-integration cycles completed before that clock (0 if it occurs at the first one), and over-range is 0.
- R5: With run/hold high, de-integration lasts exactly 2^CNT_W cycles whether or not a crossing occurred.
- R6: If no crossing occurs within 2^CNT_W de-integration cycles, the latched count is all ones and over-range is 1. Over-range never appears with a count other than all ones.
- R7: If run/hold is low at a de-integration clock after the crossing clock, de-integration ends at that clock, so it lasts (crossing count + 2) cycles. Run/hold being low before the crossing does not change the latched count.
- R8: After its minimum time, auto-zero is kept indefinitely while run/hold is low, and status stays low there.
- R9: From the parked auto-zero state, integration begins exactly WAKE_DLY clocks after the first rising clock edge that samples run/hold high. If run/hold falls during that delay, the block returns to parking and the delay restarts from zero.
- R10: Status rises at the clock edge that begins integration. It is still high just after the edge that writes the result, and it falls at the following falling clock edge, half a period later.
- R11: Count, polarity and over-range do not change while status is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Run (high) / hold (low) control |
| cmp_i | input | 1 | Integrator comparator output |
| ph_az_o | output | 1 | Auto-zero switch select |
| ph_int_o | output | 1 | Signal-integrate switch select |
| ph_deint_o | output | 1 | Reference de-integrate switch select |
| status_o | output | 1 | High from integration start until the result is stored |
| count_o | output | CNT_W | Latched conversion count |
| pol_o | output | 1 | Latched input polarity |
| ovr_o | output | 1 | Latched over-range flag |

## Verification
Assertions check on every cycle the properties that need no history. These are one-hot phase selects, the integration counter bound, the frozen polarity during de-integration, the forced all-ones count with over-range, and the result staying fixed while status is low. They also check that status rises only with integration, the exit one clock after a post-crossing hold, and that parking never jumps straight to integration. Only the bench scenarios can show the exact counts and durations. These are the latched count for every crossing position at both polarities, full-length versus shortened de-integration, the auto-zero length, the exact wake-up delay with a cancelled wake, and the half-period placement of the status fall.

// File: rtl/dsseq_pkg.sv
`timescale 1ns/1ps
package dsseq_pkg;
  typedef enum logic [2:0] {
    ST_AZ_MIN  = 3'd0,
    ST_AZ_PARK = 3'd1,
    ST_AZ_WAKE = 3'd2,
    ST_INT     = 3'd3,
    ST_DEINT   = 3'd4
  } seq_st_e;
endpackage

// File: rtl/dsseq_ctr.sv
`timescale 1ns/1ps
// Phase cycle counter shared by auto-zero, integrate and de-integrate.
module dsseq_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dsseq_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: auto-zero (minimum, parked, waking), integrate, de-integrate.
module dsseq_fsm
  import dsseq_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int INT_CNT  = 2048,
  parameter int AZ_CNT   = 2048,
  parameter int WAKE_DLY = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output seq_st_e          st_o,
  output logic             ctr_clr_o,
  output logic             lat_we_o,
  output logic             lat_ovr_o,
  output logic             pol_o,
  output logic             stat_set_o
);
  localparam int WK_W = $clog2(WAKE_DLY + 1);
  localparam logic [CNT_W-1:0] AZ_LAST  = CNT_W'(AZ_CNT - 1);
  localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_CNT - 1);
  localparam logic [CNT_W-1:0] FULL     = {CNT_W{1'b1}};
  localparam logic [WK_W-1:0]  WK_LAST  = WK_W'(WAKE_DLY - 1);

  seq_st_e         st_q, st_d;
  logic            pol_q, crossed_q;
  logic [WK_W-1:0] wk_q;
  logic            pol_ld, cross_set, cross_clr, wk_clr, wk_en, zc;

  assign zc = (cmp_i != pol_q) && !crossed_q;

  always_comb begin
    st_d       = st_q;
    ctr_clr_o  = 1'b0;
    lat_we_o   = 1'b0;
    lat_ovr_o  = 1'b0;
    stat_set_o = 1'b0;
    pol_ld     = 1'b0;
    cross_set  = 1'b0;
    cross_clr  = 1'b0;
    wk_clr     = 1'b0;
    wk_en      = 1'b0;
    case (st_q)
      ST_AZ_MIN: begin
        if (cnt_i == AZ_LAST) begin
          ctr_clr_o = 1'b1;
          if (run_i) begin
            st_d       = ST_INT;
            stat_set_o = 1'b1;
          end else begin
            st_d = ST_AZ_PARK;
          end
        end
      end
      ST_AZ_PARK: begin
        ctr_clr_o = 1'b1;
        wk_clr    = 1'b1;
        if (run_i) st_d = ST_AZ_WAKE;
      end
      ST_AZ_WAKE: begin
        ctr_clr_o = 1'b1;
        if (!run_i) begin
          st_d = ST_AZ_PARK;
        end else if (wk_q == WK_LAST) begin
          st_d       = ST_INT;
          stat_set_o = 1'b1;
        end else begin
          wk_en = 1'b1;
        end
      end
      ST_INT: begin
        if (cnt_i == INT_LAST) begin
          st_d      = ST_DEINT;
          ctr_clr_o = 1'b1;
          pol_ld    = 1'b1;
          cross_clr = 1'b1;
        end
      end
      ST_DEINT: begin
        if (zc) begin
          lat_we_o  = 1'b1;
          cross_set = 1'b1;
        end
        if (crossed_q && !run_i) begin
          st_d      = ST_AZ_MIN;
          ctr_clr_o = 1'b1;
        end else if (cnt_i == FULL) begin
          st_d      = ST_AZ_MIN;
          ctr_clr_o = 1'b1;
          if (!crossed_q && !zc) begin
            lat_we_o  = 1'b1;
            lat_ovr_o = 1'b1;
          end
        end
      end
      default: begin
        st_d      = ST_AZ_MIN;
        ctr_clr_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_AZ_MIN;
      pol_q     <= 1'b0;
      crossed_q <= 1'b0;
      wk_q      <= '0;
    end else begin
      st_q <= st_d;
      if (pol_ld) pol_q <= cmp_i;
      if (cross_clr)      crossed_q <= 1'b0;
      else if (cross_set) crossed_q <= 1'b1;
      if (wk_clr)     wk_q <= '0;
      else if (wk_en) wk_q <= wk_q + WK_W'(1);
    end
  end

  assign st_o  = st_q;
  assign pol_o = pol_q;

  AST_INT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_INT) |-> (cnt_i <= INT_LAST)); // R3
  AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEINT) |=> $stable(pol_q)); // R3
  AST_HOLD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEINT && crossed_q && !run_i) |=> (st_q == ST_AZ_MIN)); // R7
  AST_PARK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_AZ_PARK) |=> (st_q == ST_AZ_PARK || st_q == ST_AZ_WAKE)); // R8
endmodule

// File: rtl/dsseq_result.sv
`timescale 1ns/1ps
// Result latches and status flag with half-period fall.
module dsseq_result #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic         ovr_i,
  input  logic [W-1:0] cnt_i,
  input  logic         pol_i,
  input  logic         set_i,
  output logic [W-1:0] count_o,
  output logic         pol_o,
  output logic         ovr_o,
  output logic         status_o
);
  logic [W-1:0] count_q;
  logic         pol_q, ovr_q, stat_q, upd_q, neg_clr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      pol_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (we_i) begin
      count_q <= ovr_i ? {W{1'b1}} : cnt_i;
      pol_q   <= pol_i;
      ovr_q   <= ovr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= we_i;
      if (set_i)      stat_q <= 1'b1;
      else if (upd_q) stat_q <= 1'b0;
    end
  end

  // Falling-edge stage masks status half a period after the latch write.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_clr_q <= 1'b0;
    else        neg_clr_q <= upd_q;
  end

  assign status_o = stat_q && !neg_clr_q;
  assign count_o  = count_q;
  assign pol_o    = pol_q;
  assign ovr_o    = ovr_q;

  AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> !we_i); // R4
endmodule

// File: rtl/dsseq_top.sv
`timescale 1ns/1ps
module dsseq_top
  import dsseq_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int INT_CNT  = 2048,
  parameter int AZ_CNT   = 2048,
  parameter int WAKE_DLY = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             cmp_i,
  output logic             ph_az_o,
  output logic             ph_int_o,
  output logic             ph_deint_o,
  output logic             status_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pol_o,
  output logic             ovr_o
);
  logic             rst_meta_q, rst_sync_q;
  logic [CNT_W-1:0] cnt;
  seq_st_e          st;
  logic             ctr_clr, lat_we, lat_ovr, pol_held, stat_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dsseq_ctr #(.W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr_i (ctr_clr),
    .en_i  (1'b1),
    .cnt_o (cnt)
  );

  dsseq_fsm #(
    .CNT_W    (CNT_W),
    .INT_CNT  (INT_CNT),
    .AZ_CNT   (AZ_CNT),
    .WAKE_DLY (WAKE_DLY)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .run_i      (run_i),
    .cmp_i      (cmp_i),
    .cnt_i      (cnt),
    .st_o       (st),
    .ctr_clr_o  (ctr_clr),
    .lat_we_o   (lat_we),
    .lat_ovr_o  (lat_ovr),
    .pol_o      (pol_held),
    .stat_set_o (stat_set)
  );

  dsseq_result #(.W(CNT_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .we_i     (lat_we),
    .ovr_i    (lat_ovr),
    .cnt_i    (cnt),
    .pol_i    (pol_held),
    .set_i    (stat_set),
    .count_o  (count_o),
    .pol_o    (pol_o),
    .ovr_o    (ovr_o),
    .status_o (status_o)
  );

  assign ph_az_o    = (st == ST_AZ_MIN) || (st == ST_AZ_PARK) || (st == ST_AZ_WAKE);
  assign ph_int_o   = (st == ST_INT);
  assign ph_deint_o = (st == ST_DEINT);

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $countones({ph_az_o, ph_int_o, ph_deint_o}) == 1); // R1
  AST_STATUS_RISE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(status_o) |-> ph_int_o); // R10
  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !status_o |=> $stable({count_o, pol_o, ovr_o})); // R11
  AST_OVR_ONES: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ovr_o |-> (&count_o)); // R6
endmodule

// File: tb/tb_dsseq_top.sv
`timescale 1ns/1ps
module tb_dsseq_top;
  localparam int W      = 5;
  localparam int INT_N  = 8;
  localparam int AZ_N   = 6;
  localparam int DLY    = 7;
  localparam int FULL_N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n, run_i, cmp_i;
  logic         ph_az_o, ph_int_o, ph_deint_o, status_o, pol_o, ovr_o;
  logic [W-1:0] count_o;
  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  dsseq_top #(.CNT_W(W), .INT_CNT(INT_N), .AZ_CNT(AZ_N), .WAKE_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .cmp_i(cmp_i),
    .ph_az_o(ph_az_o), .ph_int_o(ph_int_o), .ph_deint_o(ph_deint_o),
    .status_o(status_o), .count_o(count_o), .pol_o(pol_o), .ovr_o(ovr_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R1 watchdog expired: actual=%0d expected<=100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One conversion. Starts from the current sample point.
  task automatic do_conv(input int n, input bit pol, input bit ovr_case,
                         input bit abort, input bit run_low, input int exp_pre,
                         input string pre_req);
    int pre = 0;
    int ic  = 0;
    int len = 0;
    int j   = 0;
    int g   = 0;
    int exp_len;
    bit st_seen = 0;
    while (!ph_int_o && g < 400) begin
      pre++; g++;
      if (status_o) st_seen = 1;
      sample();
    end
    if (exp_pre >= 0) check(pre == exp_pre, pre_req, pre, exp_pre);
    check(!st_seen && status_o, "R10 status rise", status_o, 1);
    cmp_i = pol;
    if (run_low) run_i = 1'b0;
    while (ph_int_o && g < 400) begin
      ic++; g++;
      sample();
    end
    check(ic == INT_N, "R3 integrate length", ic, INT_N);
    while (ph_deint_o && g < 400) begin
      len++; g++;
      if (!ovr_case && j == n) begin
        cmp_i = ~pol;
        @(posedge clk); #1;
        check(status_o == 1'b1 && count_o == W'(n), "R10 status high after latch edge",
              int'(status_o), 1);
        sample();
        check(status_o == 1'b0, "R10 status low half period later", status_o, 0);
        if (abort) run_i = 1'b0;
      end else begin
        sample();
      end
      j++;
    end
    if (ovr_case)               exp_len = FULL_N;
    else if (abort || run_low)  exp_len = (n + 2 < FULL_N) ? n + 2 : FULL_N;
    else                        exp_len = FULL_N;
    check(len == exp_len, (abort || run_low) ? "R7 short de-integrate" : "R5 full de-integrate",
          len, exp_len);
    if (ovr_case) begin
      check(count_o == W'(FULL_N - 1) && ovr_o, "R6 over-range result", int'(count_o), FULL_N - 1);
    end else begin
      check(count_o == W'(n), "R4 latched count", int'(count_o), n);
      check(!ovr_o, "R4 over-range clear", ovr_o, 0);
    end
    check(pol_o == pol, "R3 latched polarity", pol_o, int'(pol));
    check(!status_o, "R10 status low after result", status_o, 0);
  endtask

  task automatic park_check();
    bit ok = 1;
    for (int i = 0; i < AZ_N + 8; i++) begin
      sample();
      if (!ph_az_o || status_o) ok = 0;
    end
    check(ok, "R8 parked in auto-zero", int'(ok), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    run_i = 1'b1;
    cmp_i = 1'b0;
    repeat (4) sample();
    rst_n = 1'b1;
    sample();
    check(ph_az_o && !ph_int_o && !ph_deint_o, "R1 reset phase", ph_az_o, 1);
    check(!status_o && count_o == '0 && !pol_o && !ovr_o, "R1 reset result",
          int'(count_o), 0);

    do_conv(5, 1'b1, 1'b0, 1'b0, 1'b0, -1, "R2");
    for (int p = 0; p < 2; p++)
      for (int n = 0; n < FULL_N; n++)
        do_conv(n, p[0], 1'b0, 1'b0, 1'b0, AZ_N, "R2 auto-zero length");
    do_conv(0, 1'b0, 1'b1, 1'b0, 1'b0, AZ_N, "R2 auto-zero length");
    do_conv(0, 1'b1, 1'b1, 1'b0, 1'b0, AZ_N, "R2 auto-zero length");

    // Hold after crossing, then wake.
    do_conv(3, 1'b1, 1'b0, 1'b1, 1'b0, AZ_N, "R2 auto-zero length");
    park_check();
    run_i = 1'b1;
    do_conv(7, 1'b0, 1'b0, 1'b0, 1'b1, DLY + 1, "R9 wake delay");
    park_check();

    // Cancelled wake restarts the delay.
    run_i = 1'b1;
    repeat (3) sample();
    run_i = 1'b0;
    begin
      bit ok = 1;
      for (int i = 0; i < 12; i++) begin
        sample();
        if (!ph_az_o) ok = 0;
      end
      check(ok, "R9 cancelled wake stays parked", int'(ok), 1);
    end
    run_i = 1'b1;
    do_conv(0, 1'b1, 1'b0, 1'b1, 1'b0, DLY + 1, "R9 wake delay");
    park_check();
    run_i = 1'b1;
    do_conv(10, 1'b0, 1'b1, 1'b0, 1'b1, DLY + 1, "R9 wake delay");
    park_check();
    run_i = 1'b1;
    do_conv(2, 1'b1, 1'b0, 1'b0, 1'b0, DLY + 1, "R9 wake delay");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule